// File: doc/BRIEF.md
# Serial Flash Read-Command Responder

This block is the device side of an SPI link (mode 0) that behaves like a page-organised serial flash, but only for its read commands. A host lowers chip select, shifts an opcode and a command header in on SI, and then receives bytes on SO. Data is sent most significant bit first.

Three read paths are served:

- **Continuous read.** Streams through the main array and carries on from the end of one page into the next page.
- **Page read.** Stays inside one page and wraps back to that page's first byte.
- **Buffer read.** Streams one of two page-sized buffers and wraps inside that buffer.

The main array and both buffers are register arrays inside the block. Their contents are loaded through a backdoor write port that runs on the system clock.

SCK, CS and SI are assumed to be synchronous to `clk` and much slower than it. Each of them goes through one sampling register, and the block detects SCK edges from the sampled values. SO is modelled as a data bit plus an output enable, and the pad outside the block applies the tri-state. The page count must be a power of two.

Top module: `flash_read_responder`

## Requirements
- R1: While reset is held, `so_oe` and `so_data` are 0. Reset is synchronous and active low.
- R2: Opcodes 0x68 and 0xE8 start a continuous read. They are followed by a 56-bit header, sent MSB first:
  - 4 ignored bits;
  - an 11-bit page field;
  - a 9-bit byte field;
  - 32 ignored bits.

  On the first SCK fall after the header, SO carries bit 7 of the addressed byte. Later falls carry the following bits, MSB first.
- R3: A continuous read that leaves the last byte of a page continues at byte 0 of the next page. After the last page it continues at page 0.
- R4: Opcodes 0x52 and 0xD2 start a page read. They use the same 56-bit header as R2. After the last byte of the page, the read continues at byte 0 of the same page.
- R5: Opcodes 0x54/0xD4 read buffer 1 and 0x56/0xD6 read buffer 2. They are followed by a 32-bit header: 15 ignored bits, a 9-bit byte field, then 8 ignored bits. Data then comes out as in R2.
- R6: Each buffer and each page holds 264 bytes. A buffer read continues at byte 0 after byte 263.
- R7: A byte field of 264 or more starts the read at byte 0.
- R8: `so_oe` is 0 no later than 2 clock cycles after CS is seen high. A read that is cut off mid-byte does not disturb the next command.
- R9: Any other opcode leaves `so_oe` at 0 until CS rises.
- R10: `so_oe` stays 0 during the opcode and header phases.
- R11: Read commands never change the contents of either buffer.
- R12: The page field is taken modulo the page count.
- R13: The backdoor port writes `bd_data` on a clock edge when `bd_we` is 1. `bd_sel` picks the target:
  - 0 selects the main array, at `bd_addr` = page·264 + byte;
  - 1 selects buffer 1, at `bd_addr` = byte;
  - 2 selects buffer 2, at `bd_addr` = byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data in, sampled on SCK rise |
| so_data | output | 1 | Serial data out, changes after SCK fall |
| so_oe | output | 1 | Output enable for SO (0 = high impedance) |
| bd_we | input | 1 | Backdoor write enable |
| bd_sel | input | 2 | Backdoor target: 0 main, 1 buffer 1, 2 buffer 2 |
| bd_addr | input | BD_AW | Backdoor byte address |
| bd_data | input | 8 | Backdoor write data |

## Verification
A data bit reaches `so_data` two clock cycles after SCK falls at the pin: one cycle for the sampling register and one for the output register. The bench holds each SCK half period for four cycles and samples SO just before it raises SCK, so every bit has settled two cycles before it is sampled.

An SCK rise is seen two cycles after it reaches the pin. The bench changes SI half a period before each rise, so SI is stable when the rise is seen.

The output enable drops two cycles after CS rises. The bench checks it three cycles after raising CS.

Expected bytes come from the bench's own model of the preload pattern and of the three wrap rules.

// File: rtl/frr_pkg.sv
`timescale 1ns/1ps
// Package: shared types and command constants for the flash read responder.
// Assumes opcode pairs differ only in bit 7.
package frr_pkg;
    localparam int BYTE_FIELD = 9;   // width of the byte field in every header
    localparam int ADDR_BITS  = 24;  // leading header bits that hold address fields
    localparam int HDR_ARRAY  = 56;  // header bits for main-array reads
    localparam int HDR_BUF    = 32;  // header bits for buffer reads

    typedef enum logic [1:0] {RM_CONT, RM_PAGE, RM_BUF1, RM_BUF2} rmode_e;
    typedef enum logic [1:0] {ST_OPC, ST_HDR, ST_DATA, ST_DEAD} rstate_e;

    typedef struct packed {
        logic   ok;
        rmode_e m;
    } dec_t;

    // Maps an opcode to a read mode; ok is 0 for anything unsupported.
    function automatic dec_t decode_op(input logic [7:0] op);
        dec_t d;
        d.ok = 1'b1;
        d.m  = RM_CONT;
        case (op)
            8'h68, 8'hE8: d.m = RM_CONT;
            8'h52, 8'hD2: d.m = RM_PAGE;
            8'h54, 8'hD4: d.m = RM_BUF1;
            8'h56, 8'hD6: d.m = RM_BUF2;
            default:      d.ok = 1'b0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/frr_pin_sampler.sv
`timescale 1ns/1ps
// Pin sampler: registers CS, SCK and SI once and derives SCK edge strobes.
// Assumes the pins are already synchronous to clk and change slowly.
module frr_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_bit
);
    logic cs_q, sck_q, sck_qq, si_q;

    // Purpose: one sampling stage plus a delayed SCK copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sck_q  <= 1'b0;
            sck_qq <= 1'b0;
            si_q   <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sck_q  <= sck;
            sck_qq <= sck_q;
            si_q   <= si;
        end
    end

    assign cs_act   = ~cs_q;
    assign sck_rise = sck_q & ~sck_qq;
    assign sck_fall = ~sck_q & sck_qq;
    assign si_bit   = si_q;
endmodule

// File: rtl/frr_store.sv
`timescale 1ns/1ps
// Storage: main array of PAGES pages plus two page-sized buffers.
// Writes come only from the backdoor port; reads are asynchronous.
// Assumes callers keep addresses inside the selected array.
module frr_store #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_W     = 2,
    parameter int AW         = 11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bd_we,
    input  logic [1:0]                     bd_sel,
    input  logic [AW-1:0]                  bd_addr,
    input  logic [7:0]                     bd_data,
    input  logic [1:0]                     rd_sel,
    input  logic [PAGE_W-1:0]              rd_page,
    input  logic [frr_pkg::BYTE_FIELD-1:0] rd_byte,
    output logic [7:0]                     rd_data
);
    localparam int MAIN_BYTES = PAGES * PAGE_BYTES;
    localparam int BYTE_W     = $clog2(PAGE_BYTES);

    logic [7:0]    main_mem [MAIN_BYTES];
    logic [7:0]    buf_rd   [2];
    logic [AW-1:0] main_idx;

    // Purpose: backdoor write into the main array.
    always_ff @(posedge clk) begin
        if (bd_we && bd_sel == 2'd0) main_mem[bd_addr] <= bd_data;
    end

    // Two identical buffers, each with its own backdoor write decode.
    for (genvar g = 0; g < 2; g++) begin : g_buf
        logic [7:0] buf_mem [PAGE_BYTES];

        // Purpose: backdoor write into this buffer.
        always_ff @(posedge clk) begin
            if (bd_we && bd_sel == 2'(g + 1)) buf_mem[bd_addr[BYTE_W-1:0]] <= bd_data;
        end

        assign buf_rd[g] = buf_mem[rd_byte[BYTE_W-1:0]];
    end

    assign main_idx = AW'(rd_page) * AW'(PAGE_BYTES) + AW'(rd_byte);

    // Purpose: pick the read source for the sequencer.
    always_comb begin
        case (rd_sel)
            2'd1:    rd_data = buf_rd[0];
            2'd2:    rd_data = buf_rd[1];
            default: rd_data = main_mem[main_idx];
        endcase
    end

    // R13: backdoor addresses stay inside the selected array.
    p_bd_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bd_we |-> (bd_sel == 2'd0 ? int'(bd_addr) < MAIN_BYTES : int'(bd_addr) < PAGE_BYTES));
endmodule

// File: rtl/frr_seq.sv
`timescale 1ns/1ps
// Sequencer: shifts in opcode and header on SCK rise, then drives data bits
// on SCK fall, applying the wrap rule of the decoded read mode.
// Assumes PAGES is a power of two and PAGE_BYTES <= 512.
module frr_seq
    import frr_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_act,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  si_bit,
    input  logic [7:0]            rd_data,
    output logic [1:0]            rd_sel,
    output logic [PAGE_W-1:0]     rd_page,
    output logic [BYTE_FIELD-1:0] rd_byte,
    output logic                  so_bit,
    output logic                  so_en
);
    rstate_e               state;
    rmode_e                mode;
    logic [5:0]            cnt;
    logic [6:0]            opc_sh;
    logic [ADDR_BITS-1:0]  hdr_sh;
    logic [PAGE_W-1:0]     cur_page, start_page, next_page;
    logic [BYTE_FIELD-1:0] cur_byte, start_byte, next_byte;
    logic [2:0]            bit_idx;
    logic [5:0]            hdr_last;
    logic                  at_end;
    dec_t                  dec;
    logic                  unused_hdr;

    assign dec        = decode_op({opc_sh, si_bit});
    assign hdr_last   = (mode == RM_BUF1 || mode == RM_BUF2) ? 6'(HDR_BUF - 1) : 6'(HDR_ARRAY - 1);
    assign start_page = hdr_sh[BYTE_FIELD +: PAGE_W];
    assign start_byte = (int'(hdr_sh[BYTE_FIELD-1:0]) >= PAGE_BYTES) ? '0 : hdr_sh[BYTE_FIELD-1:0];
    assign unused_hdr = ^hdr_sh[ADDR_BITS-1:BYTE_FIELD+PAGE_W];
    assign at_end     = (int'(cur_byte) == PAGE_BYTES - 1);
    assign next_byte  = at_end ? '0 : cur_byte + 1'b1;

    // Purpose: only a continuous read moves to the next page at a page end.
    always_comb begin
        next_page = cur_page;
        if (mode == RM_CONT && at_end)
            next_page = (int'(cur_page) == PAGES - 1) ? '0 : cur_page + 1'b1;
    end

    // Purpose: command state machine, address capture and SO bit register.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            state    <= ST_OPC;
            mode     <= RM_CONT;
            cnt      <= '0;
            opc_sh   <= '0;
            hdr_sh   <= '0;
            cur_page <= '0;
            cur_byte <= '0;
            bit_idx  <= 3'd7;
            so_bit   <= 1'b0;
            so_en    <= 1'b0;
        end else begin
            case (state)
                ST_OPC: if (sck_rise) begin
                    opc_sh <= {opc_sh[5:0], si_bit};
                    cnt    <= cnt + 1'b1;
                    if (cnt == 6'd7) begin
                        cnt <= '0;
                        if (dec.ok) begin
                            mode  <= dec.m;
                            state <= ST_HDR;
                        end else begin
                            state <= ST_DEAD;
                        end
                    end
                end
                ST_HDR: if (sck_rise) begin
                    if (cnt < 6'(ADDR_BITS)) hdr_sh <= {hdr_sh[ADDR_BITS-2:0], si_bit};
                    cnt <= cnt + 1'b1;
                    if (cnt == hdr_last) begin
                        state    <= ST_DATA;
                        cur_page <= start_page;
                        cur_byte <= start_byte;
                    end
                end
                ST_DATA: if (sck_fall) begin
                    so_bit  <= rd_data[bit_idx];
                    so_en   <= 1'b1;
                    bit_idx <= bit_idx - 1'b1;
                    if (bit_idx == 3'd0) begin
                        cur_byte <= next_byte;
                        cur_page <= next_page;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_sel  = (mode == RM_BUF1) ? 2'd1 : (mode == RM_BUF2) ? 2'd2 : 2'd0;
    assign rd_page = cur_page;
    assign rd_byte = cur_byte;

    // R8: a deselected device stops driving one cycle later.
    p_quiet_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_en);
    // R10: SO is only driven once the data phase is reached.
    p_drive_only_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> state == ST_DATA);
    // R9: an unsupported opcode never drives SO.
    p_dead_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DEAD |-> !so_en);
    // R6/R7: the byte pointer never leaves the page or buffer.
    p_byte_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA |-> int'(cur_byte) < PAGE_BYTES);
    // R4: a page read never changes page while streaming.
    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && mode == RM_PAGE) |=> (state != ST_DATA || $stable(cur_page)));
endmodule

// File: rtl/flash_read_responder.sv
`timescale 1ns/1ps
// Top: serial flash read-command responder. Connects the pin sampler,
// command sequencer and storage; SO tri-state is applied by the pad.
// Assumes PAGES is a power of two.
module flash_read_responder #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 264,
    parameter int BD_AW      = $clog2(PAGES * PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             si,
    output logic             so_data,
    output logic             so_oe,
    input  logic             bd_we,
    input  logic [1:0]       bd_sel,
    input  logic [BD_AW-1:0] bd_addr,
    input  logic [7:0]       bd_data
);
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;

    logic                           cs_act, sck_rise, sck_fall, si_bit;
    logic [7:0]                     rd_data;
    logic [1:0]                     rd_sel;
    logic [PAGE_W-1:0]              rd_page;
    logic [frr_pkg::BYTE_FIELD-1:0] rd_byte;
    logic                           so_bit, so_en;

    frr_pin_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_bit(si_bit)
    );

    frr_seq #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .si_bit(si_bit), .rd_data(rd_data), .rd_sel(rd_sel),
        .rd_page(rd_page), .rd_byte(rd_byte), .so_bit(so_bit), .so_en(so_en)
    );

    frr_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .AW(BD_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .bd_we(bd_we), .bd_sel(bd_sel), .bd_addr(bd_addr),
        .bd_data(bd_data), .rd_sel(rd_sel), .rd_page(rd_page), .rd_byte(rd_byte),
        .rd_data(rd_data)
    );

    assign so_data = so_bit & so_en;
    assign so_oe   = so_en;
endmodule

// File: tb/flash_read_responder_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module flash_read_responder_bench;
    localparam int PAGES = 4;
    localparam int PB    = 264;

    logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic        bd_we = 1'b0;
    logic [1:0]  bd_sel = 2'd0;
    logic [10:0] bd_addr = '0;
    logic [7:0]  bd_data = '0;
    wire         so_data, so_oe;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_read_responder u_flash_read_responder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so_data(so_data), .so_oe(so_oe), .bd_we(bd_we), .bd_sel(bd_sel),
        .bd_addr(bd_addr), .bd_data(bd_data)
    );

    function automatic logic [7:0] mval(input int p, input int b);
        return 8'(p * 71 + b * 13 + (b >> 8) * 29 + 5);
    endfunction
    function automatic logic [7:0] bval(input int k, input int b);
        return (k == 1) ? 8'(b * 7 + (b >> 8) * 97 + 1) : 8'(b * 11 + (b >> 8) * 53 + 200);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, inout bit drove);
        sck = 1'b0; si = b; tick(4);
        if (so_oe) drove = 1'b1;
        sck = 1'b1; tick(4);
    endtask

    task automatic recv_bit(output bit b, output bit en);
        sck = 1'b0; tick(4);
        b = so_data; en = so_oe;
        sck = 1'b1; tick(4);
    endtask

    task automatic preload();
        for (int p = 0; p < PAGES; p++)
            for (int b = 0; b < PB; b++) begin
                bd_we = 1'b1; bd_sel = 2'd0; bd_addr = 11'(p * PB + b); bd_data = mval(p, b); tick(1);
            end
        for (int k = 1; k <= 2; k++)
            for (int b = 0; b < PB; b++) begin
                bd_we = 1'b1; bd_sel = 2'(k); bd_addr = 11'(b); bd_data = bval(k, b); tick(1);
            end
        bd_we = 1'b0;
    endtask

    task automatic end_cmd(input string req);
        cs_n = 1'b1; tick(3);
        chk(so_oe == 1'b0, req, int'(so_oe), 0);
        sck = 1'b0; tick(4);
    endtask

    // Issues one read and compares nbytes against the bench model.
    task automatic run_read(input logic [7:0] op, input int page_f, input int byte_f,
                            input int nbytes, input string req);
        logic [55:0] hdr;
        int  nb, kind, p, b;
        bit  drove, bt, en, en_ok;
        logic [7:0] got;
        kind = (op[6:0] == 7'h68) ? 0 : (op[6:0] == 7'h52) ? 1 : (op[6:0] == 7'h54) ? 2 : 3;
        if (kind < 2) begin
            hdr = {4'hA, 11'(page_f), 9'(byte_f), 32'hC3A5_5A3C}; nb = 56;
        end else begin
            hdr = {15'h5A5A, 9'(byte_f), 8'hE7, 24'h0}; nb = 32;
        end
        drove = 1'b0;
        cs_n = 1'b0; tick(2);
        for (int i = 7; i >= 0; i--) send_bit(op[i], drove);
        for (int i = 0; i < nb; i++) send_bit(hdr[55 - i], drove);
        chk(!drove, "R10 header hi-z", int'(drove), 0);
        p = page_f % PAGES;
        b = (byte_f >= PB) ? 0 : byte_f;
        for (int n = 0; n < nbytes; n++) begin
            en_ok = 1'b1;
            for (int i = 7; i >= 0; i--) begin
                recv_bit(bt, en);
                got[i] = bt;
                if (!en) en_ok = 1'b0;
            end
            if (kind < 2) chk(en_ok && got == mval(p, b), req, int'(got), int'(mval(p, b)));
            else          chk(en_ok && got == bval(kind - 1, b), req, int'(got), int'(bval(kind - 1, b)));
            if (b == PB - 1) begin
                b = 0;
                if (kind == 0) p = (p + 1) % PAGES;
            end else begin
                b++;
            end
        end
        end_cmd("R8 release after read");
    endtask

    task automatic t_reset();
        tick(4);
        chk(so_oe == 1'b0 && so_data == 1'b0, "R1 reset outputs", int'({so_oe, so_data}), 0);
        preload();
        rst_n = 1'b1; tick(4);
        chk(so_oe == 1'b0, "R1 idle after reset", int'(so_oe), 0);
    endtask

    task automatic t_continuous();
        run_read(8'h68, 1, 260, 8, "R2 R3 continuous across page");
        run_read(8'hE8, 3, 262, 4, "R3 continuous last page to page 0");
        run_read(8'h68, 0, 0, 2, "R2 continuous start of array");
    endtask

    task automatic t_page();
        run_read(8'h52, 2, 261, 6, "R4 page read wrap");
        run_read(8'hD2, 0, 100, 2, "R4 page read alt opcode");
        run_read(8'h52, 5 + 8, 3, 2, "R12 page field modulo");
    endtask

    task automatic t_buffers();
        run_read(8'h54, 0, 262, 4, "R5 R6 buffer 1 wrap");
        run_read(8'hD6, 0, 10, 3, "R5 buffer 2");
        run_read(8'hD4, 0, 128, 2, "R5 buffer 1 alt opcode");
        run_read(8'h56, 0, 263, 3, "R6 buffer 2 wrap");
    endtask

    task automatic t_clamp();
        run_read(8'h52, 1, 400, 2, "R7 page byte clamp");
        run_read(8'h56, 0, 511, 2, "R7 buffer byte clamp");
    endtask

    task automatic t_abort();
        bit drove, bt, en;
        logic [55:0] hdr;
        hdr = {4'h0, 11'd2, 9'd5, 32'h0};
        drove = 1'b0;
        cs_n = 1'b0; tick(2);
        for (int i = 7; i >= 0; i--) send_bit(bit'(8'h68 >> i), drove);
        for (int i = 0; i < 56; i++) send_bit(hdr[55 - i], drove);
        for (int i = 0; i < 3; i++) recv_bit(bt, en);
        end_cmd("R8 abort mid-byte");
        run_read(8'h68, 2, 5, 2, "R8 command after abort");
    endtask

    task automatic t_unknown();
        bit drove, bt, en, any_en;
        drove = 1'b0; any_en = 1'b0;
        cs_n = 1'b0; tick(2);
        for (int i = 7; i >= 0; i--) send_bit(bit'(8'h9F >> i), drove);
        for (int i = 0; i < 40; i++) begin
            recv_bit(bt, en);
            if (en) any_en = 1'b1;
        end
        chk(!drove && !any_en, "R9 unknown opcode silent", int'(any_en | drove), 0);
        end_cmd("R9 release");
        run_read(8'h54, 0, 7, 1, "R9 command after unknown");
    endtask

    task automatic t_buffers_intact();
        run_read(8'h54, 0, 0, 6, "R11 buffer 1 unchanged");
        run_read(8'h56, 0, 258, 8, "R11 buffer 2 unchanged");
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main_flow
        t_reset();
        t_continuous();
        t_page();
        t_buffers();
        t_clamp();
        t_abort();
        t_unknown();
        t_buffers_intact();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule